// File: doc/BRIEF.md
# Streaming Configuration Register Updater

This block owns the run-time identity of a network-attached accelerator: its 48-bit station address, its 12-bit VLAN identifier and the transmit clock-phase select bit. The frame classifier passes it the payload bytes of configuration frames one per cycle, with a flag on the first byte. The block writes each byte straight into the target register as it arrives. Nothing is buffered, checked or acknowledged, so a damaged or truncated frame leaves the registers partly rewritten.

The payload starts with six address bytes, most significant first. Two identifier bytes follow: the low nibble of the first is identifier bits 11:8, the upper nibble is padding, and the second is bits 7:0. All later bytes are padding. The phase select is taken from an input pin while reset is asserted, and it does not change until the next reset. The three outputs feed the classifier's address and VLAN filters and the transmitter's clock-phase selection.

Top module: `cfg_stream_updater`

## Requirements
- R1: While `rst_ni` is low, and after it rises until a write occurs, `mac_addr_o` is 48'h0090CF00BEEF.
- R2: While `rst_ni` is low, and after it rises until a write occurs, `vlan_id_o` is 12'hDAD.
- R3: A byte accepted with `cfg_valid_i`=1 and `cfg_first_i`=1 is payload byte 0 and goes to `mac_addr_o[47:40]`. Each later accepted byte goes to the next lower address byte, so payload byte 5 lands in `mac_addr_o[7:0]`. Each byte is visible on the output one clock after it is accepted.
- R4: Payload byte 6 writes its bits 3:0 into `vlan_id_o[11:8]`, and its bits 7:4 are ignored. Payload byte 7 writes `vlan_id_o[7:0]`.
- R5: Accepted bytes after payload byte 7 do not change any output until the next byte flagged with `cfg_first_i`.
- R6: In a cycle with `cfg_valid_i`=0, `cfg_byte_i` and `cfg_first_i` have no effect, and the payload position does not advance.
- R7: A byte flagged with `cfg_first_i` restarts at payload byte 0 even in the middle of a frame. Bytes already written by a shorter frame keep their new values, and unwritten fields keep their old values.
- R8: `tx_phase_sel_o` equals the level of `tx_phase_pin_i` sampled on clock edges while `rst_ni` is low (0 = no shift, 1 = 180-degree shift). It stays fixed after reset, whatever the pin or any configuration frame does.
- R9: After reset, accepted bytes that come before any byte flagged with `cfg_first_i` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset; the phase pin is sampled while it is low |
| tx_phase_pin_i | input | 1 | Phase-select strap level |
| cfg_valid_i | input | 1 | A configuration payload byte is present this cycle |
| cfg_first_i | input | 1 | Marks the present byte as payload byte 0 |
| cfg_byte_i | input | 8 | Payload byte |
| mac_addr_o | output | 48 | Current station address |
| vlan_id_o | output | 12 | Current VLAN identifier |
| tx_phase_sel_o | output | 1 | Transmit clock-phase select |

## Verification
An error in the payload position counter shows up as a byte written into the wrong address or identifier slot. It appears on the outputs one cycle after that byte. A stuck or lost position appears as padding bytes changing the registers, or as a restarted frame writing at an offset. A bad reset value is visible on the first cycle after reset. A phase flop that samples after reset changes its output on the first frame or pin toggle.

// File: rtl/cfg_upd_pkg.sv
package cfg_upd_pkg;
  localparam int unsigned MAC_BYTES = 6;
  localparam int unsigned VID_W     = 12;
  localparam logic [47:0] MAC_RESET = 48'h0090CF00BEEF;
  localparam logic [11:0] VID_RESET = 12'hDAD;
endpackage

// File: rtl/cfg_byte_tracker.sv
module cfg_byte_tracker #(
  parameter int unsigned NUM_BYTES = 8,
  parameter int unsigned IDX_W     = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             first_i,
  output logic             wr_o,
  output logic [IDX_W-1:0] idx_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_BYTES);

  logic [IDX_W-1:0] idx_q, cur_idx;

  // position NUM_BYTES means idle/padding: nothing written
  assign cur_idx = first_i ? '0 : idx_q;
  assign wr_o    = valid_i && (cur_idx < LAST);
  assign idx_o   = cur_idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= LAST;
    end else if (valid_i && (cur_idx < LAST)) begin
      idx_q <= cur_idx + IDX_W'(1);
    end
  end

  a_r7_first_restarts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && first_i) |=> (idx_q == IDX_W'(1)));
  a_r5_padding_saturates: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idx_q == LAST && !first_i) |=> (idx_q == LAST));
  a_r6_no_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_i) |=> $stable(idx_q));
endmodule

// File: rtl/cfg_field_regs.sv
module cfg_field_regs #(
  parameter int unsigned              MAC_BYTES = 6,
  parameter int unsigned              VID_W     = 12,
  parameter int unsigned              IDX_W     = 4,
  parameter logic [MAC_BYTES*8-1:0]   MAC_RESET = '0,
  parameter logic [VID_W-1:0]         VID_RESET = '0
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_i,
  input  logic [IDX_W-1:0]       idx_i,
  input  logic [7:0]             byte_i,
  output logic [MAC_BYTES*8-1:0] mac_o,
  output logic [VID_W-1:0]       vid_o
);
  localparam int unsigned MAC_W    = MAC_BYTES * 8;
  localparam int unsigned VID_HI_W = VID_W - 8;
  localparam logic [IDX_W-1:0] VID_HI_IDX = IDX_W'(MAC_BYTES);
  localparam logic [IDX_W-1:0] VID_LO_IDX = IDX_W'(MAC_BYTES + 1);

  logic [7:0]          mac_q [MAC_BYTES];
  logic [VID_HI_W-1:0] vid_hi_q;
  logic [7:0]          vid_lo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < MAC_BYTES; i++)
        mac_q[i] <= MAC_RESET[(MAC_BYTES-1-i)*8 +: 8];
      vid_hi_q <= VID_RESET[VID_W-1:8];
      vid_lo_q <= VID_RESET[7:0];
    end else if (wr_i) begin
      for (int i = 0; i < MAC_BYTES; i++)
        if (idx_i == IDX_W'(i)) mac_q[i] <= byte_i;
      if (idx_i == VID_HI_IDX) vid_hi_q <= byte_i[VID_HI_W-1:0];
      if (idx_i == VID_LO_IDX) vid_lo_q <= byte_i;
    end
  end

  // byte 0 of the payload is the most significant address byte
  for (genvar g = 0; g < MAC_BYTES; g++) begin : g_mac_pack
    assign mac_o[(MAC_BYTES-1-g)*8 +: 8] = mac_q[g];
  end
  assign vid_o = {vid_hi_q, vid_lo_q};

  a_r6_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i) |=> ($stable(mac_o) && $stable(vid_o)));
  a_r3_msb_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && idx_i == '0) |=> (mac_o[MAC_W-1 -: 8] == $past(byte_i)));
  a_r4_vid_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && idx_i == VID_LO_IDX) |=> (vid_o[7:0] == $past(byte_i)));
  a_r4_vid_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && idx_i == VID_HI_IDX) |=> (vid_o[VID_W-1:8] == $past(byte_i[VID_HI_W-1:0])));
endmodule

// File: rtl/cfg_phase_latch.sv
module cfg_phase_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic phase_o
);
  logic phase_q;

  // strap: loads only on edges while reset is held
  always_ff @(posedge clk_i) begin
    if (!rst_ni) phase_q <= pin_i;
  end
  assign phase_o = phase_q;

  a_r8_phase_fixed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> $stable(phase_o));
endmodule

// File: rtl/cfg_stream_updater.sv
module cfg_stream_updater
  import cfg_upd_pkg::*;
#(
  parameter int unsigned            P_MAC_BYTES = MAC_BYTES,
  parameter int unsigned            P_VID_W     = VID_W,
  parameter logic [P_MAC_BYTES*8-1:0] P_MAC_RESET = MAC_RESET,
  parameter logic [P_VID_W-1:0]     P_VID_RESET = VID_RESET
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     tx_phase_pin_i,
  input  logic                     cfg_valid_i,
  input  logic                     cfg_first_i,
  input  logic [7:0]               cfg_byte_i,
  output logic [P_MAC_BYTES*8-1:0] mac_addr_o,
  output logic [P_VID_W-1:0]       vlan_id_o,
  output logic                     tx_phase_sel_o
);
  localparam int unsigned FIELD_BYTES = P_MAC_BYTES + (P_VID_W + 7) / 8;
  localparam int unsigned IDX_W       = $clog2(FIELD_BYTES + 1);

  logic             wr;
  logic [IDX_W-1:0] idx;

  cfg_byte_tracker #(
    .NUM_BYTES (FIELD_BYTES),
    .IDX_W     (IDX_W)
  ) u_tracker (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (cfg_valid_i),
    .first_i (cfg_first_i),
    .wr_o    (wr),
    .idx_o   (idx)
  );

  cfg_field_regs #(
    .MAC_BYTES (P_MAC_BYTES),
    .VID_W     (P_VID_W),
    .IDX_W     (IDX_W),
    .MAC_RESET (P_MAC_RESET),
    .VID_RESET (P_VID_RESET)
  ) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (wr),
    .idx_i  (idx),
    .byte_i (cfg_byte_i),
    .mac_o  (mac_addr_o),
    .vid_o  (vlan_id_o)
  );

  cfg_phase_latch u_phase (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pin_i   (tx_phase_pin_i),
    .phase_o (tx_phase_sel_o)
  );

  a_r3_first_to_msb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_valid_i && cfg_first_i) |=> (mac_addr_o[P_MAC_BYTES*8-1 -: 8] == $past(cfg_byte_i)));
endmodule

// File: tb/cfg_stream_updater_tb.sv
module cfg_stream_updater_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tx_phase_pin_i = 1'b0;
  logic        cfg_valid_i = 1'b0;
  logic        cfg_first_i = 1'b0;
  logic [7:0]  cfg_byte_i = 8'h00;
  logic [47:0] mac_addr_o;
  logic [11:0] vlan_id_o;
  logic        tx_phase_sel_o;

  int n_tests = 0;
  int n_fail  = 0;

  always #5 clk_i = ~clk_i;

  cfg_stream_updater u_dut (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .tx_phase_pin_i (tx_phase_pin_i),
    .cfg_valid_i    (cfg_valid_i),
    .cfg_first_i    (cfg_first_i),
    .cfg_byte_i     (cfg_byte_i),
    .mac_addr_o     (mac_addr_o),
    .vlan_id_o      (vlan_id_o),
    .tx_phase_sel_o (tx_phase_sel_o)
  );

  // 10-byte payloads (8 field bytes + 2 padding) and expected {mac, vid}
  localparam logic [79:0] FRAMES [3] = '{
    80'h021122334455_F34A_AABB,
    80'hFFFFFFFFFFFF_0001_0000,
    80'h0090CF00BEEF_0DAD_1234
  };
  localparam logic [59:0] EXPECT [3] = '{
    60'h021122334455_34A,
    60'hFFFFFFFFFFFF_001,
    60'h0090CF00BEEF_DAD
  };

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at negedge, hold across posedge, return at next negedge
  task automatic send(logic [7:0] b, logic first, logic valid = 1'b1);
    cfg_byte_i  = b;
    cfg_first_i = first;
    cfg_valid_i = valid;
    @(negedge clk_i);
    cfg_valid_i = 1'b0;
    cfg_first_i = 1'b0;
  endtask

  task automatic do_reset(logic pin);
    rst_ni = 1'b0;
    tx_phase_pin_i = pin;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk_i);
    do_reset(1'b1);
    check("R1 reset mac", 64'(mac_addr_o), 64'h0090CF00BEEF);
    check("R2 reset vid", 64'(vlan_id_o), 64'hDAD);
    check("R8 phase=1", 64'(tx_phase_sel_o), 64'd1);

    // R9: bytes before any first flag are ignored
    send(8'h5A, 1'b0);
    send(8'hA5, 1'b0);
    check("R9 mac", 64'(mac_addr_o), 64'h0090CF00BEEF);
    check("R9 vid", 64'(vlan_id_o), 64'hDAD);

    // table walk: R3 R4 R5
    for (int f = 0; f < 3; f++) begin
      for (int k = 0; k < 10; k++) begin
        send(FRAMES[f][79-8*k -: 8], k == 0);
        if (k == 0) check("R3 msb next cycle", 64'(mac_addr_o[47:40]), 64'(FRAMES[f][79:72]));
      end
      check("R3 mac table", 64'(mac_addr_o), 64'(EXPECT[f][59:12]));
      check("R4 R5 vid table", 64'(vlan_id_o), 64'(EXPECT[f][11:0]));
    end

    // R5: long padding run
    for (int k = 0; k < 20; k++) send(8'(k * 7), 1'b0);
    check("R5 padding mac", 64'(mac_addr_o), 64'h0090CF00BEEF);
    check("R5 padding vid", 64'(vlan_id_o), 64'hDAD);

    // R6: idle cycles with junk on byte/first lines, mid-frame
    send(8'h10, 1'b1);
    send(8'h20, 1'b1, 1'b0);
    send(8'h30, 1'b0, 1'b0);
    check("R6 idle mac", 64'(mac_addr_o), 64'h1090CF00BEEF);
    send(8'h40, 1'b0);
    check("R6 no advance", 64'(mac_addr_o), 64'h1040CF00BEEF);

    // R7: restart mid-frame, short frame keeps partial write
    send(8'hAB, 1'b1);
    send(8'hCD, 1'b0);
    send(8'hEF, 1'b0);
    send(8'h99, 1'b1);
    check("R7 restart", 64'(mac_addr_o), 64'h99CDEF00BEEF);
    check("R7 vid kept", 64'(vlan_id_o), 64'hDAD);

    // R8: pin toggles and frames leave phase fixed
    tx_phase_pin_i = 1'b0;
    send(8'h01, 1'b1);
    repeat (3) @(negedge clk_i);
    check("R8 phase held", 64'(tx_phase_sel_o), 64'd1);

    do_reset(1'b0);
    check("R8 phase=0", 64'(tx_phase_sel_o), 64'd0);
    check("R1 re-reset mac", 64'(mac_addr_o), 64'h0090CF00BEEF);
    tx_phase_pin_i = 1'b1;
    send(8'h00, 1'b1);
    @(negedge clk_i);
    check("R8 phase held 0", 64'(tx_phase_sel_o), 64'd0);

    // R4: upper nibble of byte 6 dropped
    send(8'h00, 1'b1);
    for (int k = 1; k < 6; k++) send(8'h00, 1'b0);
    send(8'hFF, 1'b0);
    check("R4 hi nibble", 64'(vlan_id_o), 64'hFAD);
    send(8'h3C, 1'b0);
    check("R4 low byte", 64'(vlan_id_o), 64'hF3C);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule